// File: doc/BRIEF.md
# Eight-Phase Glitch-Free Clock Selector

This block places one of eight equally spaced copies of a clock onto a single output clock. It never produces a glitch or a shortened pulse while it switches. A 3-bit phase index picks the source. Each source has its own gating enable, and that enable changes only on a falling edge of the same source, so a high pulse that has started always runs to its end. When the index moves, the old source is switched off at its next falling edge. The new source is switched on only after the old one's enable has been seen cleared. That observation is synchronised into the new source's own domain, and the new enable then passes through a short chain of flops. The output is the OR of every source ANDed with its enable.

The intended use is an ordered phase search. The index steps up one position at a time (7 wraps to 0), and each step waits until the previous handover has settled. Under that rule each source watches only the phase just below it, which keeps the cross-domain feedback network small. A parameter switches to a variant in which every source watches all seven others. Generating the phases is outside this block.

Top module: `phase_clk_selector`

## Requirements
- R1: Index value k (binary, 0 to 7) on `phase_sel` selects source `clk_ph[k]` and no other.
- R2: Once a handover has settled, `clk_out` equals the selected source on every sample.
- R3: A source whose index is deselected makes no further rising edge at the output once its first falling edge after the change has passed.
- R4: A newly selected source is enabled only after the source it watches has a cleared enable. In the default mode that is the index one below it, modulo 8. Two sources are therefore never enabled together, and every high pulse at the output is exactly one source half-period long.
- R5: Across any handover, no high or low pulse at `clk_out` is shorter than one source half-period.
- R6: The second rising edge at `clk_out` after an index change comes from the newly selected source.
- R7: While `rst` is high (active-high, sampled on each source's falling edge), only source 0 is enabled, and after release the output follows `clk_ph[0]`.
- R8: Writing the index that is already selected leaves the output unchanged: it keeps following the same source with no missing or extra pulse.
- R9: A step from index 7 to index 0 is handled like any other ordered step. Source 0 waits on source 7.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | 8 | Eight clock phases, bit k being phase k |
| rst | input | 1 | Synchronous active-high reset, seen in every phase domain |
| phase_sel | input | 3 | Binary index of the phase to pass to the output |
| clk_out | output | 1 | Selected, glitch-free output clock |

## Verification
The index is walked through all eight phases in order over two laps, including the wrap from 7 to 0. This shows that each source is decoded correctly and that the right neighbour blocks it during handover. A write of the already selected index checks that a non-change causes no disturbance, and a reset in the middle of a run checks the return to phase 0. On every step the reference tracks the widths of output pulses and the edge count after the change. These tell apart a late disable (a stale edge from the old phase), an early enable (a wide merged pulse from overlap) and a mistimed gate (a sliver pulse).

// File: rtl/phsel_pkg.sv
package phsel_pkg;

    // How far each source looks before it may take over the output.
    typedef enum logic {
        FB_NEIGHBOUR = 1'b0,   // watch only the phase one index below
        FB_ALL       = 1'b1    // watch every other phase
    } fb_mode_e;

    // Index of the phase that precedes phase self in stepping order.
    function automatic int unsigned prev_idx(input int unsigned self,
                                             input int unsigned n);
        return (self + n - 1) % n;
    endfunction

    // True when source self must wait for source other to clear.
    function automatic bit watches(input fb_mode_e     mode,
                                   input int unsigned  self,
                                   input int unsigned  other,
                                   input int unsigned  n);
        if (other == self) return 1'b0;
        if (mode == FB_ALL) return 1'b1;
        return other == prev_idx(self, n);
    endfunction

endpackage

// File: rtl/phsel_decoder.sv
module phsel_decoder #(
    parameter int unsigned N_SRC = 8,
    localparam int unsigned IW   = $clog2(N_SRC)
) (
    input  logic [IW-1:0]    idx,
    output logic [N_SRC-1:0] onehot
);

    always_comb begin
        for (int k = 0; k < N_SRC; k++) begin
            onehot[k] = (idx == IW'(k));
        end
    end

endmodule

// File: rtl/phsel_feedback.sv
module phsel_feedback
    import phsel_pkg::*;
#(
    parameter int unsigned N_SRC = 8,
    parameter fb_mode_e    MODE  = FB_NEIGHBOUR
) (
    input  logic [N_SRC-1:0] en_gate,
    output logic [N_SRC-1:0] busy_raw
);

    function automatic logic [N_SRC-1:0] watch_mask(input int unsigned self);
        logic [N_SRC-1:0] m;
        for (int unsigned j = 0; j < N_SRC; j++) begin
            m[j] = watches(MODE, self, j, N_SRC);
        end
        return m;
    endfunction

    for (genvar i = 0; i < N_SRC; i++) begin : g_fb
        localparam logic [N_SRC-1:0] MASK = watch_mask(i);
        assign busy_raw[i] = |(en_gate & MASK);
    end

endmodule

// File: rtl/phsel_gate_cell.sv
module phsel_gate_cell #(
    parameter int unsigned FB_SYNC   = 2,
    parameter int unsigned EN_STAGES = 2,
    parameter bit          RST_EN    = 1'b0,
    parameter bit          RST_BUSY  = 1'b0
) (
    input  logic clk_src,
    input  logic rst,
    input  logic sel,
    input  logic busy_raw,
    output logic en_gate
);

    logic [FB_SYNC-1:0]   fb_s;
    logic [EN_STAGES-1:0] st;
    logic                 busy_sync;
    logic                 req;

    assign busy_sync = fb_s[FB_SYNC-1];
    assign req       = sel & ~busy_sync;

    // Setting walks through the chain; a dropped request clears all stages
    // on the very next falling edge of this source.
    always_ff @(negedge clk_src) begin
        if (rst) begin
            fb_s <= {FB_SYNC{RST_BUSY}};
            st   <= {EN_STAGES{RST_EN}};
        end else begin
            fb_s[0] <= busy_raw;
            for (int k = 1; k < FB_SYNC; k++) begin
                fb_s[k] <= fb_s[k-1];
            end
            st[0] <= req;
            for (int k = 1; k < EN_STAGES; k++) begin
                st[k] <= st[k-1] & req;
            end
        end
    end

    assign en_gate = st[EN_STAGES-1];

    AST_DESEL_CLEARS: assert property (@(negedge clk_src) disable iff (rst)
        !sel |=> !en_gate);                                   // R3
    AST_SET_AFTER_FREE: assert property (@(negedge clk_src) disable iff (rst)
        $rose(en_gate) |-> $past(sel) && !$past(busy_sync));  // R4
    AST_HOLD_WHILE_SEL: assert property (@(negedge clk_src) disable iff (rst)
        (en_gate && sel) |=> en_gate);                        // R2

endmodule

// File: rtl/phsel_combiner.sv
module phsel_combiner #(
    parameter int unsigned N_SRC = 8
) (
    input  logic [N_SRC-1:0] clk_src,
    input  logic [N_SRC-1:0] en_gate,
    output logic             clk_out
);

    assign clk_out = |(clk_src & en_gate);

endmodule

// File: rtl/phase_clk_selector.sv
module phase_clk_selector
    import phsel_pkg::*;
#(
    parameter int unsigned N_PHASES  = 8,
    parameter int unsigned FB_SYNC   = 2,
    parameter int unsigned EN_STAGES = 2,
    parameter fb_mode_e    FB_MODE   = FB_NEIGHBOUR,
    localparam int unsigned IW       = $clog2(N_PHASES)
) (
    input  logic [N_PHASES-1:0] clk_ph,
    input  logic                rst,
    input  logic [IW-1:0]       phase_sel,
    output logic                clk_out
);

    logic [N_PHASES-1:0] sel_oh;
    logic [N_PHASES-1:0] en_gate;
    logic [N_PHASES-1:0] busy_raw;

    phsel_decoder #(.N_SRC(N_PHASES)) u_dec (
        .idx    (phase_sel),
        .onehot (sel_oh)
    );

    phsel_feedback #(.N_SRC(N_PHASES), .MODE(FB_MODE)) u_fb (
        .en_gate  (en_gate),
        .busy_raw (busy_raw)
    );

    for (genvar i = 0; i < N_PHASES; i++) begin : g_src
        localparam bit RST_EN   = (i == 0);
        localparam bit RST_BUSY = watches(FB_MODE, i, 0, N_PHASES);

        phsel_gate_cell #(
            .FB_SYNC   (FB_SYNC),
            .EN_STAGES (EN_STAGES),
            .RST_EN    (RST_EN),
            .RST_BUSY  (RST_BUSY)
        ) u_cell (
            .clk_src  (clk_ph[i]),
            .rst      (rst),
            .sel      (sel_oh[i]),
            .busy_raw (busy_raw[i]),
            .en_gate  (en_gate[i])
        );

        AST_ENABLED_REACHES_OUT: assert property (@(negedge clk_ph[i]) disable iff (rst)
            en_gate[i] |-> clk_out);                          // R2
    end

    phsel_combiner #(.N_SRC(N_PHASES)) u_comb (
        .clk_src (clk_ph),
        .en_gate (en_gate),
        .clk_out (clk_out)
    );

    AST_SEL_ONEHOT: assert property (@(negedge clk_ph[0]) disable iff (rst)
        $onehot(sel_oh));                                     // R1
    AST_AT_MOST_ONE: assert property (@(negedge clk_ph[0]) disable iff (rst)
        $countones(en_gate) <= 1);                            // R4

endmodule

// File: tb/phase_clk_selector_test.sv
module phase_clk_selector_test;

    localparam int NP   = 8;
    localparam int HALF = 8;          // source half-period in bench ticks
    localparam int SETTLE = 128;
    localparam int WIN    = 64;

    logic          clk = 1'b0;
    logic [3:0]    cnt = 4'd0;
    logic [NP-1:0] ph;
    logic          rst = 1'b1;
    logic [2:0]    phase_sel = 3'd0;
    logic          clk_out;

    int checks = 0;
    int errors = 0;
    int ticks  = 0;

    // monitor state, written only by the driver at posedge+2
    logic mon_en = 1'b0;
    logic win_on = 1'b0;
    int   win_idx = 0;
    string win_tag = "R2";
    logic pending = 1'b0;
    int   target = 0;
    int   old_idx = 0;
    int   since_change = 0;
    int   edges = 0;

    // monitor-owned history
    logic          prev_out = 1'b0;
    logic [NP-1:0] prev_ph = '0;
    int            run = 0;
    logic          have_run = 1'b0;
    logic          mon_en_q = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cnt <= cnt + 4'd1;

    always_comb begin
        for (int i = 0; i < NP; i++) ph[i] = ((cnt - 4'(2*i)) < 4'(HALF));
    end

    phase_clk_selector uut (
        .clk_ph    (ph),
        .rst       (rst),
        .phase_sel (phase_sel),
        .clk_out   (clk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at tick %0d", req, act, exp, ticks);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model: sampled mid-tick, every tick
    always @(negedge clk) begin
        ticks++;
        if (ticks > 150000) begin
            chk(1'b0, "watchdog", ticks, 150000);
            report();
        end
        if (mon_en && !mon_en_q) begin
            have_run = 1'b0;
            run = 0;
        end
        if (mon_en) begin
            if (clk_out !== prev_out) begin
                if (have_run) begin
                    chk(run >= HALF, "R5 pulse width", run, HALF);
                    if (prev_out)
                        chk(run == HALF, "R4 high pulse (no overlap)", run, HALF);
                end
                have_run = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            if (pending) since_change++;
            if (clk_out && !prev_out && pending) begin
                edges++;
                if (edges == 2) begin
                    chk(ph[target] && !prev_ph[target], "R6 second edge from new phase",
                        int'(ph[target]), 1);
                end
                if (since_change > 2*HALF && target != old_idx) begin
                    chk(!(ph[old_idx] && !prev_ph[old_idx]) || (ph[target] && !prev_ph[target]),
                        "R3 stale edge from old phase", old_idx, target);
                end
            end
            if (win_on) begin
                chk(clk_out == ph[win_idx], win_tag, int'(clk_out), int'(ph[win_idx]));
            end
        end
        mon_en_q = mon_en;
        prev_out = clk_out;
        prev_ph  = ph;
    end

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic window(input int idx, input string tag, input int len);
        win_idx = idx;
        win_tag = tag;
        win_on  = 1'b1;
        wait_ticks(len);
        win_on  = 1'b0;
    endtask

    task automatic step_to(input int k, input string tag);
        wait_ticks(1);
        old_idx = int'(phase_sel);
        phase_sel = 3'(k);
        target = k;
        edges = 0;
        since_change = 0;
        pending = 1'b1;
        wait_ticks(SETTLE);
        pending = 1'b0;
        window(k, tag, WIN);
    endtask

    initial begin
        // R7: reset puts phase 0 on the output
        wait_ticks(40);
        rst = 1'b0;
        wait_ticks(SETTLE);
        mon_en = 1'b1;
        window(0, "R7 reset follows phase 0", WIN);

        // first lap, R2 settled output; step 7->0 is the R9 wrap
        for (int k = 1; k < NP; k++) step_to(k, "R2 settled output");
        step_to(0, "R9 wrap 7 to 0");

        // R8: rewriting the selected index has no effect
        wait_ticks(1);
        phase_sel = 3'd0;
        window(0, "R8 same index no effect", SETTLE);

        // second lap, R1 decode of every index
        for (int k = 1; k < NP; k++) step_to(k, "R1 index selects phase");
        step_to(0, "R9 wrap 7 to 0");
        step_to(1, "R1 index selects phase");
        step_to(2, "R1 index selects phase");
        step_to(3, "R1 index selects phase");

        // R7: reset mid-run returns to phase 0
        mon_en = 1'b0;
        rst = 1'b1;
        phase_sel = 3'd0;
        wait_ticks(40);
        rst = 1'b0;
        wait_ticks(SETTLE);
        mon_en = 1'b1;
        window(0, "R7 reset mid-run", WIN);
        step_to(1, "R2 settled output");

        report();
    end

endmodule